// File: doc/BRIEF.md
# Peripheral Event Routing Matrix

The block carries single-bit event signals from up to 32 producer peripherals to a set of consumer peripherals with no processor in the path. Twelve routing channels each pick one producer input, can turn it into a one-cycle pulse on a rising, falling or either edge, and can then invert it or merge it (AND / OR) with the pre-combination signal of the neighbouring lower channel. Channel 0 uses channel 11 as its neighbour. Every channel result is registered once.

Consumers subscribe to a channel by index through a per-port select register with an enable bit. A consumer output is a direct, unregistered view of the subscribed channel's registered result. All configuration arrives through a single write port (enable, address, data), and a write governs behaviour from the clock edge after the one that captured it. A reconfigured channel's edge detector is disarmed for one cycle so that the change of source cannot produce a false pulse.

Top module: `event_route_matrix`

## Requirements
- R1: Each of the 12 channels selects a producer input by bits [4:0] of its configuration word; in pass-through mode with no combination its output equals the selected input one clock later.
- R2: Bits [6:5] select the mode: 0 pass-through, 1 rising-edge pulse, 2 falling-edge pulse, 3 both-edge pulse; an edge pulse is high for exactly one cycle, registered at the first edge that sees the new input level.
- R3: Bits [8:7] select the combination: 0 none, 1 invert own signal, 2 AND with the pre-combination signal of channel n-1, 3 OR with it; channel 0 takes channel 11 as its neighbour.
- R4: Write addresses 0 to 11 hold the channel words; addresses 12 to 19 hold the consumer words, where bits [3:0] name a channel and bit 4 enables the port.
- R5: An enabled consumer output follows the named channel output in the same cycle; a disabled port, or one naming channel 12 to 15, drives 0.
- R6: A write captured at one edge governs the channel output registered at the following edge; the output of the capturing edge still follows the old settings.
- R7: After a channel write, the output registered at the next edge carries no edge pulse, even when the new source differs in level from the old one; the detector is armed again one cycle later.
- R8: During reset all channel and consumer outputs are 0; after reset every channel is pass-through of input 0 with no combination, and every consumer port is disabled.
- R9: A write to an address from 20 to 31 changes no channel and no consumer setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Producer event inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 9 | Configuration word |
| ch_o | output | 12 | Registered channel results |
| cons_o | output | 8 | Consumer event outputs |

## Verification
The hardest case to reach is the false pulse a channel could emit right after being pointed at a new source whose level differs from the old one, since it lasts one cycle and only appears when the new source is already high at the write. The stimulus parks a channel in rising-edge mode on a low input, raises a different input, then rewrites the channel to that input and watches the output on the two edges that follow, before toggling the new source to show the detector is live again. The neighbour wrap from channel 0 to channel 11 is reached by configuring both ends with opposite input levels.

// File: rtl/erm_pkg.sv
package erm_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_RISE = 2'd1,
    MODE_FALL = 2'd2,
    MODE_BOTH = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    LOP_NONE = 2'd0,
    LOP_NOT  = 2'd1,
    LOP_AND  = 2'd2,
    LOP_OR   = 2'd3
  } lop_e;

  // Edge extraction: pulses only while the detector is armed.
  function automatic logic edge_fn(edge_mode_e m, logic cur, logic prv, logic armed);
    case (m)
      MODE_PASS: return cur;
      MODE_RISE: return armed & cur & ~prv;
      MODE_FALL: return armed & ~cur & prv;
      default:   return armed & (cur ^ prv);
    endcase
  endfunction

  // Combination with the neighbouring channel's pre-combination signal.
  function automatic logic comb_fn(lop_e op, logic own, logic nbr);
    case (op)
      LOP_NONE: return own;
      LOP_NOT:  return ~own;
      LOP_AND:  return own & nbr;
      default:  return own | nbr;
    endcase
  endfunction

endpackage

// File: rtl/erm_channel.sv
module erm_channel
  import erm_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int SRC_W   = 5,
  parameter int CFG_W   = SRC_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [CFG_W-1:0]   cfg_data,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               nbr_pre,
  output logic               pre_o,
  output logic               ch_q,
  output logic [SRC_W-1:0]   src_sel_o,
  output logic [1:0]         mode_o,
  output logic [1:0]         lop_o
);
  localparam int SRC_PAD = 1 << SRC_W;

  logic [SRC_W-1:0]   src_r;
  edge_mode_e         mode_r;
  lop_e               lop_r;
  logic               prev_r;
  logic               armed_r;
  logic [SRC_PAD-1:0] src_pad;
  logic               sel;

  assign src_pad = SRC_PAD'(src_i);
  assign sel     = src_pad[src_r];
  assign pre_o   = edge_fn(mode_r, sel, prev_r, armed_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_r   <= '0;
      mode_r  <= MODE_PASS;
      lop_r   <= LOP_NONE;
      prev_r  <= 1'b0;
      armed_r <= 1'b0;
      ch_q    <= 1'b0;
    end else begin
      if (cfg_load) begin
        src_r  <= cfg_data[SRC_W-1:0];
        mode_r <= edge_mode_e'(cfg_data[SRC_W+1:SRC_W]);
        lop_r  <= lop_e'(cfg_data[SRC_W+3:SRC_W+2]);
      end
      prev_r  <= sel;
      armed_r <= ~cfg_load;
      ch_q    <= comb_fn(lop_r, pre_o, nbr_pre);
    end
  end

  assign src_sel_o = src_r;
  assign mode_o    = mode_r;
  assign lop_o     = lop_r;

endmodule

// File: rtl/erm_consumer.sv
module erm_consumer #(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CH_W:0]     cfg_data,
  input  logic [NUM_CH-1:0] ch_vec,
  output logic              en_o,
  output logic              out_o
);
  localparam int CH_PAD = 1 << CH_W;

  logic [CH_W-1:0]   chsel_r;
  logic              en_r;
  logic [CH_PAD-1:0] ch_pad;

  assign ch_pad = CH_PAD'(ch_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chsel_r <= '0;
      en_r    <= 1'b0;
    end else if (cfg_load) begin
      chsel_r <= cfg_data[CH_W-1:0];
      en_r    <= cfg_data[CH_W];
    end
  end

  assign en_o  = en_r;
  assign out_o = en_r & ch_pad[chsel_r];

endmodule

// File: rtl/event_route_matrix.sv
module event_route_matrix #(
  parameter int NUM_CH   = 12,
  parameter int NUM_SRC  = 32,
  parameter int NUM_CONS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_i,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CH+NUM_CONS)-1:0] cfg_addr,
  input  logic [$clog2(NUM_SRC)+3:0] cfg_wdata,
  output logic [NUM_CH-1:0]         ch_o,
  output logic [NUM_CONS-1:0]       cons_o
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CFG_W  = SRC_W + 4;
  localparam int ADDR_W = $clog2(NUM_CH + NUM_CONS);

  logic [NUM_CH-1:0]       pre_v;
  logic [NUM_CH-1:0]       ch_hit;
  logic [2*NUM_CH-1:0]     mode_v;
  logic [2*NUM_CH-1:0]     lop_v;
  logic [SRC_W*NUM_CH-1:0] src_v;
  logic [NUM_CONS-1:0]     cons_hit;
  logic [NUM_CONS-1:0]     cons_en_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int NBR = (i == 0) ? NUM_CH - 1 : i - 1;
    assign ch_hit[i] = cfg_we && (cfg_addr == ADDR_W'(i));
    erm_channel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CFG_W(CFG_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_load  (ch_hit[i]),
      .cfg_data  (cfg_wdata),
      .src_i     (src_i),
      .nbr_pre   (pre_v[NBR]),
      .pre_o     (pre_v[i]),
      .ch_q      (ch_o[i]),
      .src_sel_o (src_v[SRC_W*i +: SRC_W]),
      .mode_o    (mode_v[2*i +: 2]),
      .lop_o     (lop_v[2*i +: 2])
    );
  end

  for (genvar j = 0; j < NUM_CONS; j++) begin : g_cons
    assign cons_hit[j] = cfg_we && (cfg_addr == ADDR_W'(NUM_CH + j));
    erm_consumer #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cons (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cons_hit[j]),
      .cfg_data (cfg_wdata[CH_W:0]),
      .ch_vec   (ch_o),
      .en_o     (cons_en_v[j]),
      .out_o    (cons_o[j])
    );
  end

endmodule

// File: rtl/erm_checker.sv
module erm_checker
  import erm_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int NUM_SRC  = 32,
  parameter int NUM_CONS = 8,
  parameter int SRC_W    = 5,
  parameter int ADDR_W   = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        src_i,
  input logic                      cfg_we,
  input logic [ADDR_W-1:0]         cfg_addr,
  input logic [3:0]                cfg_mode_lop,
  input logic [NUM_CH-1:0]         ch_o,
  input logic [NUM_CONS-1:0]       cons_o,
  input logic [NUM_CONS-1:0]       cons_en_v,
  input logic [2*NUM_CH-1:0]       mode_v,
  input logic [2*NUM_CH-1:0]       lop_v,
  input logic [SRC_W*NUM_CH-1:0]   src_v
);

  // R8: outputs held low while reset is asserted
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r8: assert (ch_o == '0 && cons_o == '0);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R1: pass-through with no combination follows the selected input
    p_pass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[2*i +: 2] == MODE_PASS && lop_v[2*i +: 2] == LOP_NONE)
      |=> ch_o[i] == $past(src_i[src_v[SRC_W*i +: SRC_W]]));

    // R2: a rising-edge pulse lasts a single cycle
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[2*i +: 2] == MODE_RISE && lop_v[2*i +: 2] == LOP_NONE && ch_o[i])
      |=> !ch_o[i]);

    // R7: no edge pulse on the edge after a channel write
    p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(i) && cfg_mode_lop[1:0] != MODE_PASS
       && cfg_mode_lop[3:2] == LOP_NONE)
      |=> ##1 !ch_o[i]);
  end

  for (genvar j = 0; j < NUM_CONS; j++) begin : g_cchk
    // R5: a disabled consumer port drives 0
    p_cons_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cons_en_v[j] |-> !cons_o[j]);
  end

endmodule

bind event_route_matrix erm_checker #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .NUM_CONS(NUM_CONS),
  .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_i        (src_i),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_mode_lop (cfg_wdata[CFG_W-1:SRC_W]),
  .ch_o         (ch_o),
  .cons_o       (cons_o),
  .cons_en_v    (cons_en_v),
  .mode_v       (mode_v),
  .lop_v        (lop_v),
  .src_v        (src_v)
);

// File: tb/event_route_matrix_test.sv
module event_route_matrix_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [8:0]  cfg_wdata = '0;
  logic [11:0] ch_o;
  logic [7:0]  cons_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  event_route_matrix uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ch_o(ch_o), .cons_o(cons_o)
  );

  always #10 clk = ~clk;

  function automatic logic [8:0] chw(int src, int mode, int lop);
    return {lop[1:0], mode[1:0], src[4:0]};
  endfunction

  function automatic logic [8:0] cnw(int ch, bit en);
    return {4'b0, en, ch[3:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int addr, logic [8:0] data);
    cfg_we = 1'b1; cfg_addr = addr[4:0]; cfg_wdata = data;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R8 ch_o in reset", 32'(ch_o), 0);
    chk("R8 cons_o in reset", 32'(cons_o), 0);
    rst_n = 1'b1;
    tick();
    chk("R8 ch_o after reset", 32'(ch_o), 0);
    src_i[0] = 1'b1;
    tick();
    chk("R1 R8 all channels pass input 0", 32'(ch_o), 32'hFFF);
    chk("R8 consumers disabled", 32'(cons_o), 0);
    src_i[0] = 1'b0;
    tick();
  endtask

  task automatic t_pass();
    src_i[12] = 1'b1;
    wr(3, chw(12, 0, 0));
    chk("R6 old setting on capture edge", 32'(ch_o[3]), 0);
    tick();
    chk("R1 R6 new source used", 32'(ch_o[3]), 1);
    wr(12 + 2, cnw(3, 1'b1));
    chk("R4 R5 consumer follows channel", 32'(cons_o[2]), 1);
    src_i[12] = 1'b0;
    tick();
    chk("R1 channel follows low", 32'(ch_o[3]), 0);
    chk("R5 consumer follows low", 32'(cons_o[2]), 0);
  endtask

  task automatic t_edges();
    wr(6, chw(20, 1, 0)); tick();
    src_i[20] = 1'b1; tick();
    chk("R2 rise pulse", 32'(ch_o[6]), 1);
    tick();
    chk("R2 rise pulse one cycle", 32'(ch_o[6]), 0);
    src_i[20] = 1'b0; tick();
    chk("R2 no pulse on fall in rise mode", 32'(ch_o[6]), 0);
    wr(6, chw(20, 2, 0)); tick();
    src_i[20] = 1'b1; tick();
    chk("R2 no pulse on rise in fall mode", 32'(ch_o[6]), 0);
    src_i[20] = 1'b0; tick();
    chk("R2 fall pulse", 32'(ch_o[6]), 1);
    tick();
    chk("R2 fall pulse one cycle", 32'(ch_o[6]), 0);
    wr(6, chw(20, 3, 0)); tick();
    src_i[20] = 1'b1; tick();
    chk("R2 both mode rise", 32'(ch_o[6]), 1);
    tick();
    chk("R2 both mode gap", 32'(ch_o[6]), 0);
    src_i[20] = 1'b0; tick();
    chk("R2 both mode fall", 32'(ch_o[6]), 1);
    tick();
  endtask

  task automatic t_clear();
    wr(2, chw(0, 1, 0)); tick(); tick();
    src_i[7] = 1'b1;
    wr(2, chw(7, 1, 0));
    chk("R7 capture edge quiet", 32'(ch_o[2]), 0);
    tick();
    chk("R7 no pulse after source change", 32'(ch_o[2]), 0);
    tick();
    chk("R7 still quiet", 32'(ch_o[2]), 0);
    src_i[7] = 1'b0; tick();
    src_i[7] = 1'b1; tick();
    chk("R7 detector rearmed", 32'(ch_o[2]), 1);
    src_i[7] = 1'b0; tick();
  endtask

  task automatic t_logic();
    wr(4, chw(8, 0, 0));
    wr(5, chw(9, 0, 2));
    src_i[8] = 1'b1; src_i[9] = 1'b0; tick(); tick();
    chk("R3 AND 1&0", 32'(ch_o[5]), 0);
    src_i[9] = 1'b1; tick();
    chk("R3 AND 1&1", 32'(ch_o[5]), 1);
    src_i[8] = 1'b0; tick();
    chk("R3 AND 0&1", 32'(ch_o[5]), 0);
    wr(5, chw(9, 0, 3)); tick();
    chk("R3 OR 1|0", 32'(ch_o[5]), 1);
    src_i[9] = 1'b0; tick();
    chk("R3 OR 0|0", 32'(ch_o[5]), 0);
    wr(5, chw(9, 0, 1)); tick();
    chk("R3 NOT of 0", 32'(ch_o[5]), 1);
    wr(11, chw(10, 0, 0));
    wr(0, chw(3, 0, 2));
    src_i[3] = 1'b1; src_i[10] = 1'b0; tick();
    chk("R3 wrap AND with ch11 low", 32'(ch_o[0]), 0);
    src_i[10] = 1'b1; tick();
    chk("R3 wrap AND with ch11 high", 32'(ch_o[0]), 1);
    src_i[3] = 1'b0; src_i[10] = 1'b0; tick();
  endtask

  task automatic t_consumer();
    src_i[8] = 1'b1; tick();
    wr(12 + 3, cnw(12, 1'b1)); tick();
    chk("R5 out-of-range channel gives 0", 32'(cons_o[3]), 0);
    wr(12 + 3, cnw(4, 1'b0)); tick();
    chk("R5 disabled port gives 0", 32'(cons_o[3]), 0);
    wr(12 + 7, cnw(4, 1'b1));
    chk("R4 R5 last consumer follows ch4", 32'(cons_o[7]), 1);
    chk("R5 other ports unaffected", 32'(cons_o[3]), 0);
    src_i[8] = 1'b0; tick();
  endtask

  task automatic t_unused();
    wr(20, 9'h1FF);
    wr(25, 9'h1FF);
    wr(31, 9'h1FF);
    src_i[12] = 1'b1; src_i[8] = 1'b1; tick();
    chk("R9 ch3 still pass src12", 32'(ch_o[3]), 1);
    chk("R9 ch4 still pass src8", 32'(ch_o[4]), 1);
    chk("R9 consumers unchanged", 32'(cons_o), 32'h84);
    src_i[12] = 1'b0; tick();
    chk("R9 ch3 follows low", 32'(ch_o[3]), 0);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_edges();
    t_clear();
    t_logic();
    t_consumer();
    t_unused();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule